// File: doc/BRIEF.md
# Serial Transmitter Engine

This block turns bytes written by a processor into a serial bit stream on a single output line. It runs either in an asynchronous framing mode (start bit, data, optional parity, stop bit, with each bit stretched over 1, 16 or 64 transmit-clock periods) or in a synchronous mode (data bits and optional parity only, one bit per transmit-clock period). In synchronous mode the line never goes quiet while enabled: whenever no data byte is waiting, the engine sends one or two programmed fill characters instead.

A holding buffer takes one byte from the processor and a shift register carries the byte on the wire. The buffer passes its byte to the shift register at a character boundary, so the processor can keep one byte queued and consecutive characters follow each other with no idle gap. The transmit clock is a slow input sampled in the system clock domain, and the line changes only just after its falling edge. Transmission is allowed only while the clear-to-send input is low and the enable command is set; a byte already accepted still goes out after either of them withdraws permission, while a byte offered without permission is discarded.

Top module: `txs_serial_tx`

## Requirements
- R1: After reset `txd` is 1, `txempty` is 1 and `txrdy` is 0; with no character in flight (asynchronous mode, or transmission disabled) `txd` rests at 1.
- R2: While `send_break` is 1, `txd` is 0 at all times; once it clears, `txd` returns to the level the engine would otherwise drive.
- R3: Transmission is permitted only while `tx_en` is 1 and `cts_n` is 0; otherwise `txrdy` is 0.
- R4: A byte accepted into the engine is transmitted in full even if `cts_n` rises or `tx_en` falls right after it was written.
- R5: A write (`wr_stb` high) while transmission is not permitted is discarded: `txempty` stays 1 and the byte never appears on `txd`, even after permission returns.
- R6: `txempty` is 0 while a data byte waits in the buffer or is being shifted, and 1 otherwise, including while synchronous fill characters are being sent.
- R7: In synchronous mode (`sync_mode`=1) with permission and no data pending, the engine sends `sync_char1`, then, if `sync_two`=1, alternates `sync_char2`, `sync_char1`, ...; each character is data bits LSB first plus parity if enabled, without start or stop bits; after a data byte the fill restarts at `sync_char1`.
- R8: `txd` changes only in the system-clock cycle after a falling edge of `txc` has been detected (or when `send_break` changes).
- R9: In asynchronous mode one bit lasts 1, 16 or 64 `txc` periods for `baud_sel` = 0, 1, or 2/3 respectively.
- R10: `txrdy` is 1 when transmission is permitted and the buffer is empty; an accepted write makes it 0 in the next cycle; a write while the buffer is full is ignored.
- R11: An asynchronous frame is a 0 start bit, `char_len`+5 data bits (codes 0..3 give 5..8 bits) LSB first, a parity bit when `par_en`=1 (`par_odd`=0: data plus parity hold an even number of ones; 1: odd), and a 1 stop bit.
- R12: A byte waiting in the buffer is moved to the shift register at the end of the current character, making `txrdy` 1 again; its first bit follows the previous last bit with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_mode | input | 1 | 1 = synchronous framing, 0 = asynchronous |
| sync_two | input | 1 | 1 = alternate two fill characters in synchronous mode |
| char_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| baud_sel | input | 2 | Asynchronous bit length: 0 = x1, 1 = x16, 2/3 = x64 |
| sync_char1 | input | 8 | First fill character |
| sync_char2 | input | 8 | Second fill character |
| tx_en | input | 1 | Transmit enable command |
| send_break | input | 1 | Hold the line low |
| cts_n | input | 1 | Clear to send, active low |
| txc | input | 1 | Transmit bit clock (sampled) |
| wr_stb | input | 1 | Write strobe for one data byte |
| wr_data | input | 8 | Data byte to send |
| txd | output | 1 | Serial output line |
| txrdy | output | 1 | Buffer can accept a byte and transmission is permitted |
| txempty | output | 1 | No data byte pending or in flight |

## Verification
On every cycle the assertions check that the line only moves right after a detected transmit-clock fall, that it rests high whenever an asynchronous engine has nothing left, that a write without permission leaves the engine empty, and that an accepted write clears the ready flag. Frame contents, parity, the three bit lengths, gapless back-to-back characters, delivery of a byte after permission is withdrawn, the fill character sequence and its restart after data, and the break level can only be shown by the bench's scenarios, which rebuild the expected bit sequence and compare it against the sampled line.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int CHAR_W  = 8;
    localparam int FRAME_W = CHAR_W + 3;
    localparam int CNT_W   = 6;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN5 = 2'd0,
        LEN6 = 2'd1,
        LEN7 = 2'd2,
        LEN8 = 2'd3
    } char_len_e;

    typedef enum logic [1:0] {
        BAUD_X1   = 2'd0,
        BAUD_X16  = 2'd1,
        BAUD_X64  = 2'd2,
        BAUD_X64B = 2'd3
    } baud_e;

    typedef struct packed {
        logic      sync_mode;
        logic      sync_two;
        char_len_e len;
        logic      par_en;
        logic      par_odd;
        baud_e     baud;
    } mode_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEFT_W-1:0]  count;
    } frame_t;

    // Lays a character out in wire order, bit 0 goes first.
    function automatic frame_t build_frame(
        input logic [CHAR_W-1:0] d,
        input char_len_e         len,
        input logic              par_en,
        input logic              par_odd,
        input logic              async_fmt
    );
        frame_t            f;
        logic [LEFT_W-1:0] pos;
        logic              par;
        f.bits = '1;
        pos    = '0;
        par    = par_odd;
        if (async_fmt) begin
            f.bits[0] = 1'b0;
            pos       = LEFT_W'(1);
        end
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < int'(len) + 5) begin
                f.bits[pos] = d[i];
                par         = par ^ d[i];
                pos         = pos + LEFT_W'(1);
            end
        end
        if (par_en) begin
            f.bits[pos] = par;
            pos         = pos + LEFT_W'(1);
        end
        if (async_fmt) begin
            f.bits[pos] = 1'b1;
            pos         = pos + LEFT_W'(1);
        end
        f.count = pos;
        return f;
    endfunction

    // Last value of the per-bit tick counter.
    function automatic logic [CNT_W-1:0] bit_limit(input mode_t m);
        logic [CNT_W-1:0] lim;
        if (m.sync_mode) begin
            lim = '0;
        end else begin
            unique case (m.baud)
                BAUD_X1:  lim = '0;
                BAUD_X16: lim = CNT_W'(15);
                default:  lim = CNT_W'(63);
            endcase
        end
        return lim;
    endfunction

endpackage

// File: rtl/txs_clk_edge.sv
module txs_clk_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic txc,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], txc};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/txs_bit_timer.sv
module txs_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt_q;

    assign bit_end = tick && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/txs_hold_buf.sv
module txs_hold_buf #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              permit,
    input  logic              pop,
    output logic              full,
    output logic [CHAR_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr_stb && permit && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
    import txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bit_end,
    input  mode_t             mode,
    input  logic              permit,
    input  logic              buf_full,
    input  logic [CHAR_W-1:0] buf_data,
    input  logic [CHAR_W-1:0] sync1,
    input  logic [CHAR_W-1:0] sync2,
    output logic              line,
    output logic              busy,
    output logic              carrying_data,
    output logic              load,
    output logic              pop
);
    typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

    sh_state_e          state_q;
    logic [FRAME_W-1:0] sr_q;
    logic [LEFT_W-1:0]  left_q;
    logic               data_q;
    logic               sel2_q;
    logic               boundary;
    logic               want_fill;
    logic [CHAR_W-1:0]  fill_char;
    frame_t             next_f;

    assign boundary  = tick && ((state_q == SH_IDLE) ||
                                (bit_end && left_q == LEFT_W'(1)));
    assign want_fill = mode.sync_mode && permit;
    assign pop       = boundary && buf_full;
    assign load      = boundary && (buf_full || want_fill);
    assign fill_char = (sel2_q && mode.sync_two) ? sync2 : sync1;

    always_comb begin
        if (buf_full) begin
            next_f = build_frame(buf_data, mode.len, mode.par_en,
                                 mode.par_odd, !mode.sync_mode);
        end else begin
            next_f = build_frame(fill_char, mode.len, mode.par_en,
                                 mode.par_odd, 1'b0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            sr_q    <= '1;
            left_q  <= '0;
            data_q  <= 1'b0;
            sel2_q  <= 1'b0;
        end else if (load) begin
            state_q <= SH_RUN;
            sr_q    <= next_f.bits;
            left_q  <= next_f.count;
            data_q  <= buf_full;
            sel2_q  <= buf_full ? 1'b0 : (mode.sync_two & ~sel2_q);
        end else if (boundary) begin
            state_q <= SH_IDLE;
            sr_q    <= '1;
            left_q  <= '0;
            data_q  <= 1'b0;
        end else if (state_q == SH_RUN && bit_end) begin
            sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
            left_q <= left_q - LEFT_W'(1);
        end
    end

    assign busy          = (state_q == SH_RUN);
    assign carrying_data = busy && data_q;
    assign line          = busy ? sr_q[0] : 1'b1;

endmodule

// File: rtl/txs_serial_tx.sv
module txs_serial_tx
    import txs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic              sync_two,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        baud_sel,
    input  logic [CHAR_W-1:0] sync_char1,
    input  logic [CHAR_W-1:0] sync_char2,
    input  logic              tx_en,
    input  logic              send_break,
    input  logic              cts_n,
    input  logic              txc,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              txd,
    output logic              txrdy,
    output logic              txempty
);
    mode_t             mode_w;
    logic              permit;
    logic              fall_tick;
    logic              bit_end;
    logic              load;
    logic              pop;
    logic              buf_full;
    logic [CHAR_W-1:0] buf_data;
    logic              line;
    logic              busy;
    logic              carrying_data;

    assign mode_w.sync_mode = sync_mode;
    assign mode_w.sync_two  = sync_two;
    assign mode_w.len       = char_len_e'(char_len);
    assign mode_w.par_en    = par_en;
    assign mode_w.par_odd   = par_odd;
    assign mode_w.baud      = baud_e'(baud_sel);

    assign permit = tx_en && !cts_n;

    txs_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk  (clk),
        .rst  (rst),
        .txc  (txc),
        .fall (fall_tick)
    );

    txs_bit_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (fall_tick),
        .restart (load),
        .limit   (bit_limit(mode_w)),
        .bit_end (bit_end)
    );

    txs_hold_buf #(.CHAR_W(CHAR_W)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .permit  (permit),
        .pop     (pop),
        .full    (buf_full),
        .data    (buf_data)
    );

    txs_shifter shift_i (
        .clk           (clk),
        .rst           (rst),
        .tick          (fall_tick),
        .bit_end       (bit_end),
        .mode          (mode_w),
        .permit        (permit),
        .buf_full      (buf_full),
        .buf_data      (buf_data),
        .sync1         (sync_char1),
        .sync2         (sync_char2),
        .line          (line),
        .busy          (busy),
        .carrying_data (carrying_data),
        .load          (load),
        .pop           (pop)
    );

    assign txd     = send_break ? 1'b0 : line;
    assign txrdy   = permit && !buf_full;
    assign txempty = !buf_full && !carrying_data;

endmodule

// File: rtl/txs_tx_checker.sv
module txs_tx_checker (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic tick,
    input logic send_break,
    input logic tx_en,
    input logic cts_n,
    input logic wr_stb,
    input logic txrdy,
    input logic txempty,
    input logic sync_mode
);
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        (txempty && !sync_mode && !send_break) |-> txd); // R1

    AST_DROP_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !(tx_en && !cts_n) && txempty) |=> txempty); // R5

    AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (!send_break && !$past(send_break) && !$stable(txd)) |-> $past(tick)); // R8

    AST_RDY_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && txrdy) |=> !txrdy); // R10

endmodule

bind txs_serial_tx txs_tx_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .txd        (txd),
    .tick       (fall_tick),
    .send_break (send_break),
    .tx_en      (tx_en),
    .cts_n      (cts_n),
    .wr_stb     (wr_stb),
    .txrdy      (txrdy),
    .txempty    (txempty),
    .sync_mode  (sync_mode)
);

// File: tb/txs_serial_tx_tb_top.sv
module txs_serial_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_mode = 1'b0, sync_two = 1'b0;
    logic [1:0] char_len = 2'd3, baud_sel = 2'd0;
    logic       par_en = 1'b0, par_odd = 1'b0;
    logic [7:0] sync_char1 = 8'h16, sync_char2 = 8'hA7;
    logic       tx_en = 1'b0, send_break = 1'b0, cts_n = 1'b0;
    logic       txc = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, txrdy, txempty;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    always begin
        repeat (8) @(negedge clk);
        txc = ~txc;
    end

    txs_serial_tx dut_i (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .sync_two(sync_two),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .baud_sel(baud_sel), .sync_char1(sync_char1), .sync_char2(sync_char2),
        .tx_en(tx_en), .send_break(send_break), .cts_n(cts_n), .txc(txc),
        .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd), .txrdy(txrdy),
        .txempty(txempty)
    );

    // Line log: one sample per rising txc edge, mid-way between falls.
    logic logb [0:4095];
    int   logn = 0;
    logic cap  = 1'b0;
    always @(posedge txc) begin
        if (cap && logn < 4096) begin
            logb[logn] = txd;
            logn++;
        end
    end

    // Edge-alignment monitor: no line change while txc stays high.
    int   edge_viol = 0;
    logic prev_txc = 1'b1, prev_txd = 1'b1, prev_brk = 1'b0;
    always @(negedge clk) begin
        if (!rst && txc && prev_txc && send_break == prev_brk && txd !== prev_txd)
            edge_viol++;
        prev_txc = txc;
        prev_txd = txd;
        prev_brk = send_break;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 190000);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wait_empty(input string req);
        int t = 0;
        while (!txempty && t < 30000) begin
            @(negedge clk);
            t++;
        end
        check(txempty === 1'b1, req, txempty, 1);
    endtask

    task automatic start_log();
        cap  = 1'b0;
        logn = 0;
        cap  = 1'b1;
    endtask

    // Rebuilds the expected asynchronous frame and compares it to the log.
    task automatic check_frame(input int from, input bit exact, input int factor,
                               input logic [7:0] d, input logic [1:0] len,
                               input logic pe, input logic po,
                               input string req, output int next_idx);
        int          s;
        int          nb;
        logic [10:0] exp;
        logic [10:0] got;
        logic        p;
        s = from;
        if (!exact)
            while (s < logn && logb[s] !== 1'b0) s++;
        nb  = 0;
        exp = '0;
        got = '0;
        exp[nb] = 1'b0; nb++;
        p = po;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(len) + 5) begin
                exp[nb] = d[i];
                p = p ^ d[i];
                nb++;
            end
        end
        if (pe) begin exp[nb] = p; nb++; end
        exp[nb] = 1'b1; nb++;
        for (int k = 0; k < nb; k++) begin
            int idx;
            idx = s + k * factor + factor / 2;
            got[k] = (idx < logn) ? logb[idx] : 1'bx;
        end
        check(got === exp, req, 32'(got), 32'(exp));
        next_idx = s + nb * factor;
    endtask

    function automatic logic [7:0] char_at(input int idx);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = (idx + i < logn) ? logb[idx + i] : 1'bx;
        return c;
    endfunction

    function automatic int zeros_from(input int idx);
        int z = 0;
        for (int i = idx; i < logn; i++) if (logb[i] !== 1'b1) z++;
        return z;
    endfunction

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] len;
        logic       pe;
        logic       po;
        logic [1:0] baud;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{d: 8'hA5, len: 2'd3, pe: 1'b0, po: 1'b0, baud: 2'd0},
        '{d: 8'h3C, len: 2'd0, pe: 1'b1, po: 1'b0, baud: 2'd0},
        '{d: 8'hFF, len: 2'd2, pe: 1'b1, po: 1'b1, baud: 2'd0},
        '{d: 8'h5A, len: 2'd3, pe: 1'b1, po: 1'b1, baud: 2'd0},
        '{d: 8'h2B, len: 2'd1, pe: 1'b1, po: 1'b0, baud: 2'd1},
        '{d: 8'h80, len: 2'd3, pe: 1'b0, po: 1'b0, baud: 2'd2},
        '{d: 8'h0F, len: 2'd3, pe: 1'b1, po: 1'b0, baud: 2'd3}
    };

    initial begin
        int n1, n2, s, hit, fcheck;
        tick_clk(4);
        rst = 1'b0;
        tick_clk(2);

        // Reset state
        check(txd === 1'b1, "R1 reset txd", txd, 1);
        check(txempty === 1'b1, "R1 reset txempty", txempty, 1);
        check(txrdy === 1'b0, "R1 reset txrdy", txrdy, 0);

        // Permission gating of txrdy
        tx_en = 1'b1; cts_n = 1'b0; tick_clk(1);
        check(txrdy === 1'b1, "R10 ready when permitted", txrdy, 1);
        cts_n = 1'b1; tick_clk(1);
        check(txrdy === 1'b0, "R3 cts high blocks", txrdy, 0);
        cts_n = 1'b0; tx_en = 1'b0; tick_clk(1);
        check(txrdy === 1'b0, "R3 enable low blocks", txrdy, 0);

        // Vector table: asynchronous frames at several formats and rates
        for (int v = 0; v < NVEC; v++) begin
            int f;
            char_len = VECS[v].len;
            par_en   = VECS[v].pe;
            par_odd  = VECS[v].po;
            baud_sel = VECS[v].baud;
            tx_en    = 1'b1;
            cts_n    = 1'b0;
            f = (VECS[v].baud == 2'd0) ? 1 : (VECS[v].baud == 2'd1) ? 16 : 64;
            start_log();
            tick_clk(32);
            write_byte(VECS[v].d);
            check(txempty === 1'b0, "R6 busy after write", txempty, 0);
            wait_empty("R6 empty after frame");
            tick_clk(48);
            cap = 1'b0;
            check_frame(0, 1'b0, f, VECS[v].d, VECS[v].len, VECS[v].pe,
                        VECS[v].po, (f == 1) ? "R11 frame" : "R9 bit length", n1);
            check(txd === 1'b1, "R1 idle after frame", txd, 1);
        end
        baud_sel = 2'd0; char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;

        // Write while not permitted is dropped
        tx_en = 1'b1; cts_n = 1'b1;
        start_log();
        tick_clk(2);
        write_byte(8'h00);
        check(txempty === 1'b1, "R5 dropped write keeps empty", txempty, 1);
        tick_clk(16 * 20);
        cts_n = 1'b0;
        tick_clk(16 * 20);
        cap = 1'b0;
        check(zeros_from(0) == 0, "R5 dropped byte never sent", zeros_from(0), 0);

        // Permission withdrawn right after a write
        start_log();
        tick_clk(32);
        write_byte(8'h96);
        cts_n = 1'b1;
        wait_empty("R4 empty after late frame");
        tick_clk(48);
        cap = 1'b0;
        check_frame(0, 1'b0, 1, 8'h96, 2'd3, 1'b0, 1'b0, "R4 frame after disable", n1);
        check(txrdy === 1'b0, "R3 no ready while cts high", txrdy, 0);
        cts_n = 1'b0;
        tick_clk(2);

        // Back-to-back characters and write while full
        start_log();
        tick_clk(32);
        write_byte(8'h3A);
        check(txrdy === 1'b0, "R10 ready drops after write", txrdy, 0);
        fcheck = 0;
        while (!txrdy && fcheck < 2000) begin tick_clk(1); fcheck++; end
        check(txrdy === 1'b1, "R12 ready again after handoff", txrdy, 1);
        write_byte(8'hC5);
        check(txrdy === 1'b0, "R10 buffer full", txrdy, 0);
        write_byte(8'hFF);
        wait_empty("R12 empty after pair");
        tick_clk(48);
        cap = 1'b0;
        check_frame(0, 1'b0, 1, 8'h3A, 2'd3, 1'b0, 1'b0, "R12 first frame", n1);
        check_frame(n1, 1'b1, 1, 8'hC5, 2'd3, 1'b0, 1'b0, "R12 gapless second frame", n2);
        check(zeros_from(n2) == 0, "R10 write while full ignored", zeros_from(n2), 0);

        // Break
        send_break = 1'b1;
        tick_clk(1);
        check(txd === 1'b0, "R2 break low", txd, 0);
        tick_clk(60);
        check(txd === 1'b0, "R2 break held", txd, 0);
        send_break = 1'b0;
        tick_clk(1);
        check(txd === 1'b1, "R2 break cleared", txd, 1);

        // Synchronous fill
        tx_en = 1'b0;
        sync_mode = 1'b1; sync_two = 1'b1;
        sync_char1 = 8'h16; sync_char2 = 8'hA7;
        tick_clk(4);
        start_log();
        tx_en = 1'b1;
        tick_clk(16 * 40);
        check(txempty === 1'b1, "R6 empty during fill", txempty, 1);
        s = 0;
        while (s < logn && logb[s] !== 1'b0) s++;
        check(char_at(s) === 8'h16, "R7 first fill", char_at(s), 8'h16);
        check(char_at(s + 8) === 8'hA7, "R7 second fill", char_at(s + 8), 8'hA7);
        check(char_at(s + 16) === 8'h16, "R7 alternation", char_at(s + 16), 8'h16);
        write_byte(8'hC3);
        check(txempty === 1'b0, "R6 data pending in sync", txempty, 0);
        wait_empty("R6 empty after sync data");
        tick_clk(16 * 20);
        cap = 1'b0;
        hit = -1;
        for (int k = s; k + 8 <= logn; k += 8)
            if (hit < 0 && char_at(k) === 8'hC3) hit = k;
        check(hit >= 0, "R7 data on char boundary", hit, 0);
        if (hit >= 0)
            check(char_at(hit + 8) === 8'h16, "R7 fill restarts", char_at(hit + 8), 8'h16);
        tx_en = 1'b0;
        tick_clk(16 * 24);
        check(txd === 1'b1, "R1 mark when disabled", txd, 1);
        sync_mode = 1'b0;
        tick_clk(4);

        check(edge_viol == 0, "R8 line moves only after txc fall", edge_viol, 0);

        finish_run();
    end

endmodule